// File: doc/BRIEF.md
# Block-Wise Inhibiting Spatial Pooler

This block turns one binary input patch into a sparse binary feature map with one bit per column. Every column watches its own slice of the patch and owns one programmable 8-bit weight per watched bit. A weight only takes part when it is above a shared connection threshold. For each column, the block adds up the weights that take part and sit under a set input bit. The result is the column's overlap score.

Columns are grouped into fixed, consecutive inhibition groups. Inside each group, the largest overlap is the bar. Each column that reaches the bar outputs 1, and every other column outputs 0. Ties all win, so a group whose overlaps are all zero lights every one of its columns.

A pass starts with a one-cycle `start` pulse, which captures the patch and the threshold. The groups are then handled one at a time, each in three cycles: score, maximum, write. A one-cycle `done` marks the end of the pass. Weights are loaded through a single-entry write port while the block is idle.

Top module: `sp_block_inhibit`

## Requirements
- R1: A weight counts toward an overlap only when it is strictly greater than the threshold captured at `start`. A weight equal to or below the threshold contributes 0.
- R2: Column c watches input bits c*RF_BITS through c*RF_BITS+RF_BITS-1. Its overlap is the sum of its connected weights whose input bit is 1.
- R3: Inhibition group k holds columns k*BLK_COLS through k*BLK_COLS+BLK_COLS-1, and each group is decided independently of the others. `feat_map` bit c belongs to column c.
- R4: A column's output bit is 1 exactly when its overlap equals the largest overlap in its group. Every tied column outputs 1.
- R5: A group in which every overlap is zero outputs all ones.
- R6: `done` is high for exactly one cycle, 3*NUM_BLKS clock edges after the edge that accepts `start`. The complete map is on `feat_map` while `done` is high and is held until the next pass writes it.
- R7: A `start` pulse while `busy` is high is ignored. The running pass keeps its captured patch and finishes on schedule, and no second `done` follows.
- R8: After reset, `feat_map`, `done` and `busy` are 0, and every weight is 0.
- R9: A write with `wr_en` stores `wr_data` as the weight of input bit `wr_addr`; that is, column wr_addr/RF_BITS, position wr_addr%RF_BITS. The write is used by every later pass.
- R10: The overlap is wide enough that a column with every weight at 255 and every input bit set scores its full sum without wrapping, and it beats a column of 254s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Weight write strobe |
| wr_addr | input | AW (7) | Weight index, equal to column*RF_BITS + bit position |
| wr_data | input | WW (8) | Unsigned weight value |
| conn_thresh | input | WW (8) | Connection threshold, captured at start |
| start | input | 1 | Pass request, accepted only when idle |
| img | input | NUM_COLS*RF_BITS (128) | Binary input patch, captured at start |
| busy | output | 1 | High while a pass runs |
| done | output | 1 | One-cycle end-of-pass pulse |
| feat_map | output | NUM_COLS (16) | Binary feature map, one bit per column |

## Verification
Two situations are hard to reach from random stimulus alone. One is exact ties: several columns landing on the same group maximum, including the all-zero group. The other is weights sitting exactly on the connection threshold. Random weights are therefore drawn mostly from the threshold value and its two neighbours, and directed passes build equal columns, columns all at the threshold, and columns at 255 against 254. A `start` pulse is also injected in the middle of a running pass with a different patch, so the bench can show that the original result and timing survive.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int SP_WW = 8;

  typedef enum logic [1:0] {
    SP_IDLE  = 2'd0,
    SP_SCORE = 2'd1,
    SP_PEAK  = 2'd2,
    SP_EMIT  = 2'd3
  } sp_state_e;
endpackage

// File: rtl/sp_weight_bank.sv
module sp_weight_bank #(
  parameter int N_W = 128,
  parameter int WW  = 8,
  parameter int AW  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WW-1:0]     wr_data,
  output logic [N_W*WW-1:0] w_flat
);
  logic [WW-1:0] mem [N_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_W; i++) mem[i] <= '0;
    end else if (wr_en && (int'(wr_addr) < N_W)) begin
      mem[wr_addr] <= wr_data;
    end
  end

  for (genvar g = 0; g < N_W; g++) begin : g_flat
    assign w_flat[g*WW +: WW] = mem[g];
  end
endmodule

// File: rtl/sp_col_overlap.sv
module sp_col_overlap #(
  parameter int RF = 8,
  parameter int WW = 8,
  parameter int OW = 12
) (
  input  logic [RF*WW-1:0] w_vec,
  input  logic [RF-1:0]    bits,
  input  logic [WW-1:0]    thresh,
  output logic [OW-1:0]    ovl
);
  function automatic logic [OW-1:0] score(input logic [RF*WW-1:0] w,
                                          input logic [RF-1:0] b,
                                          input logic [WW-1:0] t);
    logic [OW-1:0] acc;
    acc = '0;
    for (int j = 0; j < RF; j++) begin
      if (b[j] && (w[j*WW +: WW] > t)) acc = acc + OW'(w[j*WW +: WW]);
    end
    return acc;
  endfunction

  assign ovl = score(w_vec, bits, thresh);

  always_comb begin
    if (bits == '0) AST_QUIET_REGION: assert (ovl == '0); // R2
  end
endmodule

// File: rtl/sp_group_peak.sv
module sp_group_peak #(
  parameter int B  = 4,
  parameter int OW = 12
) (
  input  logic [B*OW-1:0] ovl_flat,
  output logic [OW-1:0]   peak
);
  function automatic logic [OW-1:0] biggest(input logic [B*OW-1:0] v);
    logic [OW-1:0] m;
    m = '0;
    for (int i = 0; i < B; i++) begin
      if (v[i*OW +: OW] > m) m = v[i*OW +: OW];
    end
    return m;
  endfunction

  assign peak = biggest(ovl_flat);
endmodule

// File: rtl/sp_block_inhibit.sv
module sp_block_inhibit #(
  parameter int NUM_COLS = 16,
  parameter int BLK_COLS = 4,
  parameter int RF_BITS  = 8,
  parameter int WW       = sp_pkg::SP_WW,
  localparam int IMG_BITS = NUM_COLS * RF_BITS,
  localparam int AW       = $clog2(IMG_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [WW-1:0]       wr_data,
  input  logic [WW-1:0]       conn_thresh,
  input  logic                start,
  input  logic [IMG_BITS-1:0] img,
  output logic                busy,
  output logic                done,
  output logic [NUM_COLS-1:0] feat_map
);
  import sp_pkg::*;

  localparam int NUM_BLKS = NUM_COLS / BLK_COLS;
  localparam int OW       = WW + $clog2(RF_BITS + 1);
  localparam int BIW      = (NUM_BLKS > 1) ? $clog2(NUM_BLKS) : 1;
  localparam int GRP_W    = BLK_COLS * OW;

  sp_state_e            state;
  logic [BIW-1:0]       blk_q;
  logic [IMG_BITS-1:0]  img_q;
  logic [WW-1:0]        thr_q;
  logic [GRP_W-1:0]     ovl_q;
  logic [OW-1:0]        peak_q;
  logic [NUM_COLS-1:0]  feat_q;
  logic                 done_q;

  logic [IMG_BITS*WW-1:0] w_flat;
  logic [NUM_COLS*OW-1:0] col_ovl;
  logic [GRP_W-1:0]       grp_ovl;
  logic [OW-1:0]          peak_c;
  logic [BLK_COLS-1:0]    win;

  // named events for the checks
  logic ev_launch, ev_last;
  assign ev_launch = start && (state == SP_IDLE);
  assign ev_last   = (state == SP_EMIT) && (int'(blk_q) == NUM_BLKS - 1);

  sp_weight_bank #(.N_W(IMG_BITS), .WW(WW), .AW(AW)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .w_flat(w_flat)
  );

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    sp_col_overlap #(.RF(RF_BITS), .WW(WW), .OW(OW)) u_ovl (
      .w_vec (w_flat[c*RF_BITS*WW +: RF_BITS*WW]),
      .bits  (img_q[c*RF_BITS +: RF_BITS]),
      .thresh(thr_q),
      .ovl   (col_ovl[c*OW +: OW])
    );
  end

  assign grp_ovl = col_ovl[int'(blk_q)*GRP_W +: GRP_W];

  sp_group_peak #(.B(BLK_COLS), .OW(OW)) u_peak (
    .ovl_flat(ovl_q), .peak(peak_c)
  );

  for (genvar i = 0; i < BLK_COLS; i++) begin : g_win
    assign win[i] = (ovl_q[i*OW +: OW] >= peak_q);

    AST_PEAK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SP_EMIT) |-> (ovl_q[i*OW +: OW] <= peak_q)); // R4
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= SP_IDLE;
      blk_q  <= '0;
      img_q  <= '0;
      thr_q  <= '0;
      ovl_q  <= '0;
      peak_q <= '0;
      feat_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        SP_IDLE: begin
          if (start) begin
            img_q <= img;
            thr_q <= conn_thresh;
            blk_q <= '0;
            state <= SP_SCORE;
          end
        end
        SP_SCORE: begin
          ovl_q <= grp_ovl;
          state <= SP_PEAK;
        end
        SP_PEAK: begin
          peak_q <= peak_c;
          state  <= SP_EMIT;
        end
        SP_EMIT: begin
          feat_q[int'(blk_q)*BLK_COLS +: BLK_COLS] <= win;
          if (ev_last) begin
            done_q <= 1'b1;
            state  <= SP_IDLE;
          end else begin
            blk_q <= blk_q + 1'b1;
            state <= SP_SCORE;
          end
        end
        default: state <= SP_IDLE;
      endcase
    end
  end

  assign busy     = (state != SP_IDLE);
  assign done     = done_q;
  assign feat_map = feat_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(ev_last)); // R6
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(img_q)); // R7
  AST_WINNER_EXISTS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SP_EMIT) |-> (win != '0)); // R4
  AST_ZERO_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == SP_EMIT) && (ovl_q == '0)) |-> (&win)); // R5
endmodule

// File: tb/tb_sp_block_inhibit.sv
module tb_sp_block_inhibit;
  localparam int NC = 16, BC = 4, RF = 8, NB = NC / BC, NW = NC * RF;
  localparam time TCK = 20ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [6:0]    wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic [7:0]    conn_thresh = '0;
  logic          start = 1'b0;
  logic [NW-1:0] img = '0;
  logic          busy, done;
  logic [NC-1:0] feat_map;

  int n_chk = 0, n_fail = 0;
  logic [7:0] wt [NW];

  always #(TCK/2) clk = ~clk;

  sp_block_inhibit dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .conn_thresh(conn_thresh), .start(start), .img(img),
    .busy(busy), .done(done), .feat_map(feat_map)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected map: groups scored one by one, winners are those at the group maximum
  function automatic logic [NC-1:0] expect_map(input logic [NW-1:0] im, input logic [7:0] t);
    logic [NC-1:0] m;
    int sc [NC];
    for (int c = 0; c < NC; c++) begin
      sc[c] = 0;
      for (int j = 0; j < RF; j++)
        if (im[c*RF+j] == 1'b1 && int'(wt[c*RF+j]) > int'(t)) sc[c] += int'(wt[c*RF+j]);
    end
    for (int g = 0; g < NB; g++) begin
      int top = 0;
      for (int i = 0; i < BC; i++) if (sc[g*BC+i] > top) top = sc[g*BC+i];
      for (int i = 0; i < BC; i++) m[g*BC+i] = (sc[g*BC+i] == top);
    end
    return m;
  endfunction

  task automatic put_w(input int a, input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 7'(a); wr_data = v;
    wt[a] = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clear_w();
    for (int a = 0; a < NW; a++) put_w(a, 8'd0);
  endtask

  // one pass; returns edges from accept to done, optional mid-pass start
  task automatic run(input logic [NW-1:0] im, input logic [7:0] t, input bit poke,
                     output int lat);
    @(negedge clk);
    img = im; conn_thresh = t; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    for (int k = 0; k < 200; k++) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (poke && lat == 4) begin
        img = ~im; conn_thresh = 8'd0; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      if (done) break;
    end
    img = '0;
  endtask

  initial begin
    #(TCK * 200000);
    n_fail++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int lat;
    logic [NC-1:0] ex;
    logic [NW-1:0] im;
    logic [7:0] t;
    void'($urandom(32'd2024));
    for (int a = 0; a < NW; a++) wt[a] = 8'd0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(feat_map == '0, "R8 reset map", 32'(feat_map), 0);
    check(done == 1'b0 && busy == 1'b0, "R8 reset done/busy", {30'd0, done, busy}, 0);

    // reset weights are zero, every group ties at zero
    run({NW{1'b1}}, 8'd0, 1'b0, lat);
    check(feat_map == 16'hFFFF, "R8 R5 zero weights all ones", 32'(feat_map), 32'hFFFF);
    check(lat == 3 * NB, "R6 latency", 32'(lat), 32'(3 * NB));
    @(negedge clk);
    check(done == 1'b0, "R6 done single cycle", 32'(done), 0);
    check(feat_map == 16'hFFFF, "R6 map held", 32'(feat_map), 32'hFFFF);

    // R1: weights exactly at the threshold do not count
    for (int j = 0; j < RF; j++) begin
      put_w(0 * RF + j, 8'd100);
      put_w(1 * RF + j, 8'd101);
    end
    run({NW{1'b1}}, 8'd100, 1'b0, lat);
    check(feat_map == 16'hFFF2, "R1 threshold strict", 32'(feat_map), 32'hFFF2);

    // R10: full-scale column against 254s
    for (int j = 0; j < RF; j++) begin
      put_w(0 * RF + j, 8'd255);
      put_w(1 * RF + j, 8'd254);
    end
    run({NW{1'b1}}, 8'd0, 1'b0, lat);
    check(feat_map == 16'hFFF1, "R10 no overflow", 32'(feat_map), 32'hFFF1);

    // R4: ties in group 1, R9 write addressing
    clear_w();
    for (int j = 0; j < RF; j++) begin
      put_w(4 * RF + j, 8'd50);
      put_w(5 * RF + j, 8'd40);
      put_w(6 * RF + j, 8'd50);
    end
    run({NW{1'b1}}, 8'd10, 1'b0, lat);
    check(feat_map == 16'hFF5F, "R4 R9 ties all win", 32'(feat_map), 32'hFF5F);

    // R2: removing column 4's input leaves column 6 alone on top
    im = {NW{1'b1}};
    im[4*RF +: RF] = '0;
    run(im, 8'd10, 1'b0, lat);
    check(feat_map == 16'hFF4F, "R2 receptive region", 32'(feat_map), 32'hFF4F);

    // R7: start while busy is ignored
    run({NW{1'b1}}, 8'd10, 1'b1, lat);
    check(lat == 3 * NB, "R7 latency kept", 32'(lat), 32'(3 * NB));
    check(feat_map == 16'hFF5F, "R7 original patch kept", 32'(feat_map), 32'hFF5F);
    begin
      int extra = 0;
      for (int k = 0; k < 3 * NB + 2; k++) begin
        @(negedge clk);
        if (done || busy) extra++;
      end
      check(extra == 0, "R7 no second pass", 32'(extra), 0);
    end

    // random rounds, weights clustered on the threshold (R1 R2 R3 R4 R5)
    for (int r = 0; r < 12; r++) begin
      t = 8'($urandom_range(1, 254));
      for (int a = 0; a < NW; a++) begin
        int pick = $urandom_range(0, 5);
        logic [7:0] v;
        case (pick)
          0: v = t - 8'd1;
          1: v = t;
          2: v = t + 8'd1;
          3: v = 8'd0;
          default: v = 8'($urandom_range(0, 255));
        endcase
        put_w(a, v);
      end
      for (int w = 0; w < NW / 32; w++) im[w*32 +: 32] = $urandom();
      if (r == 3) im[8*RF +: 4*RF] = '0;
      ex = expect_map(im, t);
      run(im, t, 1'b0, lat);
      check(feat_map == ex, "R3 R4 random group map", 32'(feat_map), 32'(ex));
      check(lat == 3 * NB, "R6 random latency", 32'(lat), 32'(3 * NB));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule